// File: doc/BRIEF.md
# Asynchronous Static RAM Read/Write Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM that shares one bidirectional byte lane for reads and writes. The host presents one request at a time on a valid/ready handshake: a read carries an address, and a write carries an address and a byte. The controller turns each request into a timed strobe sequence on the memory pins. Those pins are the address, an active-low chip enable, an active-high select, an active-low write enable and an active-low output enable. The data lane is split into an output value, an output-drive enable and an input value. The integrator combines them into a tri-state pad.

Wait states are counted in clock cycles. Each count is the ceiling of a nanosecond figure over the clock period, and never less than one. The nanosecond figure comes from the memory speed grade, chosen by parameter. A read holds the strobes for the access time and samples the lane in its last wait cycle. It then returns the byte with a one-cycle valid pulse. After a read, the controller stays off the lane for the output-disable time before it accepts the next request. This keeps host drive from colliding with memory drive. Variants of the memory without the select pin are handled by a parameter that holds the select output high.

Top module: `sram_rw_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `mem_ce_n`=1, `mem_sel`=0 (when the select is enabled), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0.
- R2: Wait counts are computed as max(1, ceil(t/CLK_PERIOD_NS)). The read count and the write-pulse count use the access time, and the turnaround count uses the output-disable time. The access times for SPEED_GRADE 0,1,2,3,4 are 20,25,30,35,45 ns. The output-disable times for the same grades are 8,10,15,20,25 ns.
- R3: For a read accepted on edge 0, the controller holds `mem_ce_n`=0, `mem_sel`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly the read count of cycles. It samples `mem_dq_in` at the end of the last of those cycles and raises `rsp_valid` for one cycle with that byte. `mem_we_n` and `mem_oe_n` are never low together.
- R4: `mem_dq_oe` is 0 in every cycle in which `mem_oe_n` is 0, and in the cycle before `mem_oe_n` falls.
- R5: After the read strobes end, the controller keeps `mem_ce_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=0 for exactly the turnaround count of cycles. Only then does it accept another request.
- R6: A write takes these steps in order, with `mem_addr` and `mem_dq_out` held constant and `mem_dq_oe`=1 throughout:
  - one setup cycle with the chip selected and `mem_we_n`=1;
  - then `mem_we_n`=0 for exactly the write-pulse count of cycles;
  - then one hold cycle with `mem_we_n`=1.
- R7: `req_ready` is 1 only while idle. A request held while `req_ready`=0 and withdrawn before `req_ready` returns has no effect on the memory.
- R8: A byte written to an address is returned by a later read of that address. This holds at the lowest and highest addresses and after an overwrite.
- R9: With HAS_SEL=0, `mem_sel` is held at 1 at all times, including reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the shared lane |
| mem_dq_oe | output | 1 | Drive enable for the shared lane |
| mem_dq_in | input | 8 | Byte read from the shared lane |

## Verification
A wrong sequencer state or counter shows at the pins within one clock. It appears as a strobe run one cycle too short or too long, a valid pulse in the wrong cycle, or `req_ready` returning early. The memory model returns a poison byte until the output enable has been low long enough, so sampling one cycle early shows up as a wrong read byte on the very next response. Drive overlapping the output enable, or an address moving under a low write enable, is flagged in the cycle it happens. A lost or misplaced write appears only at the later read-back of that address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_TURN  = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WHOLD = 3'd5
  } seq_state_e;

  // Access time (address/chip-enable to valid, also the cycle time) per grade.
  function automatic int unsigned grade_access_ns(input int unsigned grade);
    case (grade)
      0:       return 20;
      1:       return 25;
      2:       return 30;
      3:       return 35;
      default: return 45;
    endcase
  endfunction

  // Output-enable to high impedance per grade.
  function automatic int unsigned grade_release_ns(input int unsigned grade);
    case (grade)
      0:       return 8;
      1:       return 10;
      2:       return 15;
      3:       return 20;
      default: return 25;
    endcase
  endfunction

  // Whole clock cycles covering a time, at least one.
  function automatic int unsigned cycles_for(input int unsigned t_ns,
                                             input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RD_CNT  = 3,
  parameter int unsigned TRN_CNT = 2,
  parameter int unsigned WR_CNT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output seq_state_e        state_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              cap_en
);

  localparam int unsigned MAX_CNT = (RD_CNT > WR_CNT) ?
                                    ((RD_CNT > TRN_CNT) ? RD_CNT : TRN_CNT) :
                                    ((WR_CNT > TRN_CNT) ? WR_CNT : TRN_CNT);
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CNT - 1);
  localparam logic [CNT_W-1:0] TRN_LAST = CNT_W'(TRN_CNT - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_CNT - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (state_q == ST_RD) && (cnt_q == RD_LAST);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = req_write ? ST_WSET : ST_RD;
      end
      ST_RD: begin
        if (cnt_q == RD_LAST) begin
          state_d = ST_TURN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_q == TRN_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WSET: begin
        state_d = ST_WPUL;
        cnt_d   = '0;
      end
      ST_WPUL: begin
        if (cnt_q == WR_LAST) begin
          state_d = ST_WHOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WHOLD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter bit HAS_SEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_d,
  output logic       ce_n,
  output logic       sel,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  logic selected_d, we_n_d, oe_n_d, drv_d;

  // Decode the upcoming state into the pin levels it needs.
  always_comb begin
    selected_d = (state_d == ST_RD)   || (state_d == ST_WSET) ||
                 (state_d == ST_WPUL) || (state_d == ST_WHOLD);
    we_n_d     = (state_d != ST_WPUL);
    oe_n_d     = (state_d != ST_RD);
    drv_d      = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
                 (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= ~selected_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= drv_d;
    end
  end

  generate
    if (HAS_SEL) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel <= 1'b0;
        else        sel <= selected_d;
      end
    end else begin : g_nosel
      assign sel = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cap_en;
      if (cap_en) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_rw_ctrl.sv
module sram_rw_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_GRADE   = 1,
  parameter bit          HAS_SEL       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned ACC_NS  = grade_access_ns(SPEED_GRADE);
  localparam int unsigned REL_NS  = grade_release_ns(SPEED_GRADE);
  localparam int unsigned RD_CNT  = cycles_for(ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned WR_CNT  = cycles_for(ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned TRN_CNT = cycles_for(REL_NS, CLK_PERIOD_NS);

  logic       rst_meta_n, rst_sync_n;
  seq_state_e state_d;
  logic       cap_en;

  // Reset: asserted at once, released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sram_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_CNT (RD_CNT),
    .TRN_CNT(TRN_CNT),
    .WR_CNT (WR_CNT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .state_d  (state_d),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .cap_en   (cap_en)
  );

  sram_pin_drv #(
    .HAS_SEL(HAS_SEL)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .state_d(state_d),
    .ce_n   (mem_ce_n),
    .sel    (mem_sel),
    .we_n   (mem_we_n),
    .oe_n   (mem_oe_n),
    .dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap_en(cap_en),
    .dq_in (mem_dq_in),
    .rvalid(rsp_valid),
    .rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_rw_ctrl_chk.sv
module sram_rw_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);  // R4

  AST_DRIVE_OFF_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));  // R4

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));  // R3

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R3

  AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out)));  // R6

  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n));  // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);  // R7

endmodule

bind sram_rw_ctrl sram_rw_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_rw_ctrl_tb.sv
module sram_rw_ctrl_tb;

  localparam int CLK_NS = 10;
  localparam int GRADE  = 2;
  // Expected counts from R2 for a 30 ns grade at 10 ns: ceil(30/10)=3, ceil(15/10)=2
  localparam int EXP_RD  = 3;
  localparam int EXP_WR  = 3;
  localparam int EXP_TRN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic        ns_ready, ns_rsp_valid, ns_ce_n, ns_sel, ns_we_n, ns_oe_n, ns_dq_oe;
  logic [7:0]  ns_rdata, ns_dq_out;
  logic [16:0] ns_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sram_rw_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE), .HAS_SEL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  sram_rw_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE), .HAS_SEL(1'b0)) u_dut_nosel (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(ns_ready),
    .req_write(1'b0), .req_addr(17'd0), .req_wdata(8'd0),
    .rsp_valid(ns_rsp_valid), .rsp_rdata(ns_rdata), .mem_addr(ns_addr),
    .mem_ce_n(ns_ce_n), .mem_sel(ns_sel), .mem_we_n(ns_we_n),
    .mem_oe_n(ns_oe_n), .mem_dq_out(ns_dq_out), .mem_dq_oe(ns_dq_oe),
    .mem_dq_in(8'd0)
  );

  // Memory model: returns poison until output enable has been low for EXP_RD-1 edges.
  logic [7:0] mem [int];
  int         rd_run = 0;
  logic       selected, reading;
  assign selected = mem_sel && !mem_ce_n;
  assign reading  = selected && mem_we_n && !mem_oe_n;
  assign mem_dq_in = (reading && rd_run >= EXP_RD - 1) ?
                     (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'hEE;

  always @(posedge clk) begin
    if (selected && !mem_we_n) mem[int'(mem_addr)] = mem_dq_out;
    rd_run = reading ? rd_run + 1 : 0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus contention monitor (R4)
  always @(negedge clk) begin
    if (rst_n && !mem_oe_n && mem_dq_oe) begin
      n_checks++; n_fail++;
      $display("FAIL R4 drive during output enable: actual=1 expected=0");
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "ce_n", int'(mem_ce_n), 1);
    chk("R1", "sel", int'(mem_sel), 0);
    chk("R1", "we_n", int'(mem_we_n), 1);
    chk("R1", "oe_n", int'(mem_oe_n), 1);
    chk("R1", "dq_oe", int'(mem_dq_oe), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R9", "nosel sel in reset", int'(ns_sel), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ready after release", int'(req_ready), 1);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int we_low = 0;
    int bad_drv = 0;
    int bad_addr = 0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        // R6 setup cycle
        chk("R6", "setup we_n", int'(mem_we_n), 1);
        chk("R6", "setup ce_n", int'(mem_ce_n), 0);
      end
      if (k <= 5) begin
        if (!mem_dq_oe) bad_drv++;
        if (mem_addr != a || mem_dq_out != d) bad_addr++;
        chk("R7", "ready low while busy", int'(req_ready), 0);
      end
      if (k >= 2 && k <= 1 + EXP_WR && mem_we_n) bad_drv++;
      if (!mem_we_n) we_low++;
      if (k == 5) chk("R6", "hold we_n", int'(mem_we_n), 1);
      if (k == 6) begin
        chk("R7", "ready after write", int'(req_ready), 1);
        chk("R8", "idle ce_n", int'(mem_ce_n), 1);
        chk("R8", "idle sel", int'(mem_sel), 0);
        chk("R8", "idle dq_oe", int'(mem_dq_oe), 0);
      end
    end
    chk("R6", "we_n low cycles", we_low, EXP_WR);
    chk("R6", "drive/strobe faults", bad_drv, 0);
    chk("R6", "addr/data moved", bad_addr, 0);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp_d,
                         input bit busy_poke);
    int oe_low = 0;
    int vpos = 0;
    int vcnt = 0;
    logic [7:0] got = 8'h00;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 1; k <= EXP_RD + EXP_TRN + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = busy_poke;
        if (busy_poke) begin
          // R7 competing write offered while busy, withdrawn before idle
          req_write = 1'b1; req_addr = a; req_wdata = ~exp_d;
        end
      end
      if (k == EXP_RD + EXP_TRN) req_valid = 1'b0;
      if (!mem_oe_n) begin
        oe_low++;
        chk("R3", "sel during read", int'(mem_sel), 1);
        chk("R3", "we_n during read", int'(mem_we_n), 1);
      end
      if (rsp_valid) begin
        vcnt++; vpos = k; got = rsp_rdata;
      end
      if (k > EXP_RD && k <= EXP_RD + EXP_TRN) begin
        chk("R5", "turn ce_n", int'(mem_ce_n), 1);
        chk("R5", "turn ready", int'(req_ready), 0);
        chk("R5", "turn dq_oe", int'(mem_dq_oe), 0);
      end
      if (k == EXP_RD + EXP_TRN + 1) chk("R5", "ready after turn", int'(req_ready), 1);
    end
    chk("R2", "oe_n low cycles", oe_low, EXP_RD);
    chk("R3", "rsp_valid count", vcnt, 1);
    chk("R3", "rsp_valid cycle", vpos, EXP_RD + 1);
    chk("R8", "read data", int'(got), int'(exp_d));
  endtask

  initial begin
    do_reset();
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'h5A);
    do_write(17'h0ABCD, 8'h3C);
    do_read(17'h00000, 8'hA5, 1'b0);
    do_read(17'h1FFFF, 8'h5A, 1'b0);
    do_read(17'h0ABCD, 8'h3C, 1'b1);
    do_read(17'h0ABCD, 8'h3C, 1'b0);  // R7 poke left no trace
    do_write(17'h00000, 8'hC3);
    do_read(17'h00000, 8'hC3, 1'b0);  // R8 overwrite
    do_read(17'h00123, 8'h00, 1'b0);
    chk("R9", "nosel sel after run", int'(ns_sel), 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule